// File: doc/BRIEF.md
# Programmable March Element Test Engine

This block is a memory self-test engine steered by a host processor through a handful of write-only registers. The host loads a data background, a low and a high address bound and one march element instruction, then writes a go command. The engine walks the address range in the requested order. At every address it issues the instruction's list of reads and writes to a synchronous single-port SRAM, one operation per clock. Each read is checked against the background or its complement.

A full algorithm is built by the host as a series of elements, one go per element. The error flag, the first failing address with its read data, and the completion flag are sticky across elements, so the host runs a whole sequence such as March C- and reads the verdict at the end. Any-order elements run ascending by default. A parameter flips them to descending.

Top module: `mbist_march_engine`

## Requirements
- R1: Host writes with `host_wr` high select a register by `host_addr`: 0 background, 1 low bound, 2 high bound, 3 element instruction, 4 control. Writes to registers 0 to 3 while `busy` is high leave those registers unchanged.
- R2: Direction code 2'b00 walks from the low bound up to the high bound inclusive. At each address the operations are issued in slot order, one per clock, and `mem_en` is high only while `busy` is high.
- R3: Direction code 2'b01 walks from the high bound down to the low bound. Codes 2'b10 and 2'b11 (any order) walk ascending when ANY_DOWN is 0.
- R4: Instruction bits [4:2] give the operation count. For slot i, bit 5+2i set means write and clear means read, and bit 6+2i set selects the inverted background. A write drives the background, or its complement, onto `mem_wdata`.
- R5: A read's data is compared one cycle after the read is issued, against the background or its complement as the slot selects. A mismatch sets `err`, which stays set until cleared. `fail_addr` and `fail_data` hold the address and read data of the first mismatch only.
- R6: Reset clears `busy`, `done`, `err` and `mem_en`. An element with k operations over n addresses sets `done` k*n+1 clocks after the go write. `done` stays set until the host clears it.
- R7: Control bit 0 (go) has no effect while `busy` is high.
- R8: Control bit 1 clears `done` and control bit 2 clears `err`, each independently of the other.
- R9: An operation count of 0 completes in one clock with no memory access. A count above 4 is treated as 4.
- R10: The six-element March C- sequence takes 10N+6 clocks on N words. It ends with `err` clear on a fault-free memory, and on a memory with a single stuck bit it reports that word's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register select |
| host_wdata | input | HW | Host write data |
| busy | output | 1 | Element in progress |
| done | output | 1 | Sticky element-complete flag |
| err | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of first mismatch |
| fail_data | output | DW | Data read at first mismatch |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | AW | SRAM address |
| mem_wdata | output | DW | SRAM write data |
| mem_rdata | input | DW | SRAM read data, one clock after the read |

## Verification
The bench records every SRAM access and compares the address order against both bounds for each direction code. An off-by-one walk or a reversed any-order element shows up as a wrong trace. A write-then-read element at the same address catches a compare that runs at the wrong cycle, because a misaligned compare would flag a clean memory. It also sweeps a stuck-at-1 and a stuck-at-0 bit over every word under March C-. A design that overwrote the captured failure, or that took a new go or bound write in the middle of a run, would report the wrong address or issue extra accesses after `done`.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
   localparam int unsigned OP_SLOTS = 4;
   localparam int unsigned CNT_W    = 3;
   localparam int unsigned INSTR_W  = 2 + CNT_W + 2 * OP_SLOTS;
   localparam int unsigned OPI_W    = $clog2(OP_SLOTS);

   typedef enum logic [2:0] {
      RA_BG    = 3'd0,
      RA_LO    = 3'd1,
      RA_HI    = 3'd2,
      RA_INSTR = 3'd3,
      RA_CTRL  = 3'd4
   } reg_sel_e;

   typedef struct packed {
      logic inv;
      logic wr;
   } op_t;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_RUN    = 2'd1,
      ST_FINISH = 2'd2
   } state_e;
endpackage

// File: rtl/mbist_regs.sv
module mbist_regs
   import mbist_pkg::*;
#(
   parameter int unsigned AW = 6,
   parameter int unsigned DW = 8,
   parameter int unsigned HW = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic [2:0]         host_addr,
   input  logic [HW-1:0]      host_wdata,
   input  logic               busy,
   output logic [DW-1:0]      bg,
   output logic [AW-1:0]      lo,
   output logic [AW-1:0]      hi,
   output logic [INSTR_W-1:0] instr,
   output logic               go,
   output logic               clr_done,
   output logic               clr_err
);
   logic cfg_wr;
   logic ctrl_wr;

   assign cfg_wr   = host_wr && !busy;
   assign ctrl_wr  = host_wr && (host_addr == RA_CTRL);
   assign go       = ctrl_wr && host_wdata[0] && !busy;
   assign clr_done = ctrl_wr && host_wdata[1];
   assign clr_err  = ctrl_wr && host_wdata[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bg    <= '0;
         lo    <= '0;
         hi    <= '0;
         instr <= '0;
      end else if (cfg_wr) begin
         case (host_addr)
            RA_BG:    bg    <= host_wdata[DW-1:0];
            RA_LO:    lo    <= host_wdata[AW-1:0];
            RA_HI:    hi    <= host_wdata[AW-1:0];
            RA_INSTR: instr <= host_wdata[INSTR_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
   parameter int unsigned AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          adv,
   input  logic          down,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   output logic [AW-1:0] addr,
   output logic          at_end
);
   localparam logic [AW-1:0] ONE = AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr <= '0;
      else if (load) addr <= down ? hi : lo;
      else if (adv)  addr <= down ? addr - ONE : addr + ONE;
   end

   assign at_end = (addr == (down ? lo : hi));
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
   import mbist_pkg::*;
#(
   parameter int unsigned AW       = 6,
   parameter int unsigned DW       = 8,
   parameter bit          ANY_DOWN = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic               clr_done,
   input  logic               clr_err,
   input  logic [INSTR_W-1:0] instr,
   input  logic [DW-1:0]      bg,
   input  logic [AW-1:0]      addr,
   input  logic               at_end,
   input  logic [DW-1:0]      mem_rdata,
   output logic               down,
   output logic               load,
   output logic               adv,
   output logic               busy,
   output logic               done,
   output logic               err,
   output logic [AW-1:0]      fail_addr,
   output logic [DW-1:0]      fail_data,
   output logic               mem_en,
   output logic               mem_we,
   output logic [DW-1:0]      mem_wdata
);
   state_e           state;
   logic [OPI_W-1:0] op_idx;
   logic [CNT_W-1:0] cnt_raw;
   logic [CNT_W-1:0] n_ops;
   op_t              ops [OP_SLOTS];
   op_t              cur_op;
   logic             last_op;
   logic             rd_pend;
   logic [AW-1:0]    rd_addr;
   logic [DW-1:0]    rd_exp;
   logic             mism;

   for (genvar g = 0; g < OP_SLOTS; g++) begin : g_slot
      assign ops[g] = op_t'(instr[6+2*g -: 2]);
   end

   if (ANY_DOWN) begin : g_any_down
      assign down = instr[1] | instr[0];
   end else begin : g_any_up
      assign down = !instr[1] && instr[0];
   end

   assign cnt_raw   = instr[2 +: CNT_W];
   assign n_ops     = (cnt_raw > CNT_W'(OP_SLOTS)) ? CNT_W'(OP_SLOTS) : cnt_raw;
   assign cur_op    = ops[op_idx];
   assign last_op   = ((CNT_W'(op_idx) + CNT_W'(1)) == n_ops);
   assign busy      = (state != ST_IDLE);
   assign mem_en    = (state == ST_RUN);
   assign mem_we    = cur_op.wr;
   assign mem_wdata = cur_op.inv ? ~bg : bg;
   assign load      = go;
   assign adv       = (state == ST_RUN) && last_op && !at_end;
   assign mism      = rd_pend && (mem_rdata != rd_exp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         op_idx <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               op_idx <= '0;
               if (go) state <= (n_ops == '0) ? ST_FINISH : ST_RUN;
            end
            ST_RUN: begin
               if (last_op) begin
                  op_idx <= '0;
                  if (at_end) state <= ST_FINISH;
               end else begin
                  op_idx <= op_idx + OPI_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         rd_addr <= '0;
         rd_exp  <= '0;
      end else begin
         rd_pend <= mem_en && !cur_op.wr;
         rd_addr <= addr;
         rd_exp  <= mem_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         err       <= 1'b0;
         fail_addr <= '0;
         fail_data <= '0;
      end else begin
         if (state == ST_FINISH) done <= 1'b1;
         else if (clr_done)      done <= 1'b0;
         err <= (err && !clr_err) || mism;
         if (mism && (!err || clr_err)) begin
            fail_addr <= rd_addr;
            fail_data <= mem_rdata;
         end
      end
   end
endmodule

// File: rtl/mbist_march_engine.sv
module mbist_march_engine
   import mbist_pkg::*;
#(
   parameter int unsigned AW       = 6,
   parameter int unsigned DW       = 8,
   parameter int unsigned HW       = 16,
   parameter bit          ANY_DOWN = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic [2:0]    host_addr,
   input  logic [HW-1:0] host_wdata,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic [AW-1:0] fail_addr,
   output logic [DW-1:0] fail_data,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);
   if (HW < INSTR_W || HW < AW || HW < DW || HW < 3) begin : g_bad_hw
      $error("host data width too narrow for the register set");
   end
   if (AW < 1 || DW < 1) begin : g_bad_size
      $error("address and data widths must be nonzero");
   end

   logic [DW-1:0]      reg_bg;
   logic [AW-1:0]      reg_lo;
   logic [AW-1:0]      reg_hi;
   logic [INSTR_W-1:0] reg_instr;
   logic               go;
   logic               clr_done;
   logic               clr_err;
   logic               load;
   logic               adv;
   logic               down;
   logic               at_end;
   logic [AW-1:0]      cur_addr;

   mbist_regs #(.AW(AW), .DW(DW), .HW(HW)) u_regs (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .busy(busy), .bg(reg_bg), .lo(reg_lo),
      .hi(reg_hi), .instr(reg_instr), .go(go), .clr_done(clr_done),
      .clr_err(clr_err)
   );

   mbist_addr_gen #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .down(down),
      .lo(reg_lo), .hi(reg_hi), .addr(cur_addr), .at_end(at_end)
   );

   mbist_seq #(.AW(AW), .DW(DW), .ANY_DOWN(ANY_DOWN)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .clr_done(clr_done),
      .clr_err(clr_err), .instr(reg_instr), .bg(reg_bg), .addr(cur_addr),
      .at_end(at_end), .mem_rdata(mem_rdata), .down(down), .load(load),
      .adv(adv), .busy(busy), .done(done), .err(err),
      .fail_addr(fail_addr), .fail_data(fail_data), .mem_en(mem_en),
      .mem_we(mem_we), .mem_wdata(mem_wdata)
   );

   assign mem_addr = cur_addr;
endmodule

// File: rtl/mbist_march_checker.sv
module mbist_march_checker
   import mbist_pkg::*;
#(
   parameter int unsigned AW = 6,
   parameter int unsigned DW = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               done,
   input logic               err,
   input logic [AW-1:0]      fail_addr,
   input logic [DW-1:0]      fail_data,
   input logic               mem_en,
   input logic [AW-1:0]      mem_addr,
   input logic [AW-1:0]      lo,
   input logic [AW-1:0]      hi,
   input logic [INSTR_W-1:0] instr,
   input logic [DW-1:0]      bg,
   input logic               clr_err
);
   p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_en);

   p_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (mem_addr >= lo && mem_addr <= hi));

   p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(lo) && $stable(hi) && $stable(instr) && $stable(bg)));

   p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr_err) |=> err);

   p_first_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr_err) |=> ($stable(fail_addr) && $stable(fail_data)));
endmodule

bind mbist_march_engine mbist_march_checker #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
   .fail_addr(fail_addr), .fail_data(fail_data), .mem_en(mem_en),
   .mem_addr(mem_addr), .lo(reg_lo), .hi(reg_hi), .instr(reg_instr),
   .bg(reg_bg), .clr_err(clr_err)
);

// File: tb/mbist_march_engine_bench.sv
module mbist_march_engine_bench;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int HW = 16;
   localparam int N  = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_wr = 1'b0;
   logic [2:0]    host_addr = '0;
   logic [HW-1:0] host_wdata = '0;
   logic          busy, done, err, mem_en, mem_we;
   logic [AW-1:0] fail_addr, mem_addr;
   logic [DW-1:0] fail_data, mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   mbist_march_engine #(.AW(AW), .DW(DW), .HW(HW)) u_mbist_march_engine (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .busy(busy), .done(done), .err(err),
      .fail_addr(fail_addr), .fail_data(fail_data), .mem_en(mem_en),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   // behavioural SRAM with one injectable stuck bit
   logic [DW-1:0] ram [N];
   logic          flt_on = 1'b0;
   logic [AW-1:0] flt_a = '0;
   int            flt_b = 0;
   logic          flt_v = 1'b0;

   function automatic logic [DW-1:0] stick(input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [DW-1:0] r;
      r = d;
      if (flt_on && a == flt_a) r[flt_b] = flt_v;
      return r;
   endfunction

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) ram[mem_addr] <= stick(mem_addr, mem_wdata);
         else        mem_rdata     <= stick(mem_addr, ram[mem_addr]);
      end
   end

   // access trace
   int            tr_n = 0;
   logic [AW-1:0] tr_a [256];
   logic          tr_w [256];
   always @(negedge clk) begin
      if (rst_n && mem_en && tr_n < 256) begin
         tr_a[tr_n] = mem_addr;
         tr_w[tr_n] = mem_we;
         tr_n++;
      end
   end

   task automatic finish_up();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [HW-1:0] mk(input logic [1:0] dir, input logic [2:0] cnt,
                                        input logic [3:0] wr, input logic [3:0] inv);
      logic [HW-1:0] r;
      r = '0;
      r[1:0] = dir;
      r[4:2] = cnt;
      for (int i = 0; i < 4; i++) begin
         r[5+2*i] = wr[i];
         r[6+2*i] = inv[i];
      end
      return r;
   endfunction

   task automatic hw(input logic [2:0] a, input logic [HW-1:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic run(input logic [HW-1:0] ins, output int cyc);
      hw(3'd4, 16'h0002);
      hw(3'd3, ins);
      tr_n = 0;
      hw(3'd4, 16'h0001);
      cyc = 0;
      while (!done && cyc < 2000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic march_c(output int total);
      int c;
      total = 0;
      run(mk(2'b10, 3'd1, 4'b0001, 4'b0000), c); total += c;
      run(mk(2'b00, 3'd2, 4'b0010, 4'b0010), c); total += c;
      run(mk(2'b00, 3'd2, 4'b0010, 4'b0001), c); total += c;
      run(mk(2'b01, 3'd2, 4'b0010, 4'b0010), c); total += c;
      run(mk(2'b01, 3'd2, 4'b0010, 4'b0001), c); total += c;
      run(mk(2'b10, 3'd1, 4'b0000, 4'b0000), c); total += c;
   endtask

   initial begin
      int cyc;
      int tot;
      int k;
      repeat (3) @(negedge clk);
      chk("R6 reset busy", busy, 0);
      chk("R6 reset done", done, 0);
      chk("R6 reset err", err, 0);
      chk("R6 reset mem_en", mem_en, 0);
      rst_n = 1'b1;

      // R1, R4: write background over the whole array
      hw(3'd0, 16'h00A5); hw(3'd1, 16'd0); hw(3'd2, 16'd15);
      run(mk(2'b00, 3'd1, 4'b0001, 4'b0000), cyc);
      chk("R6 cycles 1 op", cyc, 17);
      for (int i = 0; i < N; i++) chk("R4 true background", ram[i], 8'hA5);

      // R3 any order (2'b10) ascending, R4 inverted background
      run(mk(2'b10, 3'd1, 4'b0001, 4'b0001), cyc);
      for (int i = 0; i < N; i++) chk("R4 inverted background", ram[i], 8'h5A);
      for (int i = 0; i < N; i++) chk("R3 any order ascends", tr_a[i], i);

      // R2 ascending two ops over 3..9
      hw(3'd1, 16'd3); hw(3'd2, 16'd9);
      run(mk(2'b00, 3'd2, 4'b0010, 4'b0001), cyc);
      chk("R6 cycles 2 ops", cyc, 15);
      chk("R2 trace length", tr_n, 14);
      for (int i = 0; i < 14; i++) begin
         chk("R2 ascending addr", tr_a[i], 3 + i / 2);
         chk("R2 slot order", tr_w[i], i % 2);
      end
      chk("R5 clean read", err, 0);

      // R3 descending
      run(mk(2'b01, 3'd2, 4'b0010, 4'b0010), cyc);
      for (int i = 0; i < 14; i++) chk("R3 descending addr", tr_a[i], 9 - i / 2);
      chk("R5 clean descending", err, 0);

      // R3 code 2'b11 ascends
      run(mk(2'b11, 3'd1, 4'b0000, 4'b0001), cyc);
      for (int i = 0; i < 7; i++) chk("R3 code 11 ascends", tr_a[i], 3 + i);
      chk("R5 clean any", err, 0);

      // R5 mismatch capture: ram 3..9 holds 5A, read expects A5
      run(mk(2'b01, 3'd1, 4'b0000, 4'b0000), cyc);
      chk("R5 err set", err, 1);
      chk("R5 first fail addr", fail_addr, 9);
      chk("R5 fail data", fail_data, 8'h5A);
      run(mk(2'b00, 3'd1, 4'b0000, 4'b0000), cyc);
      chk("R5 err sticky", err, 1);
      chk("R5 first fail kept", fail_addr, 9);

      // R8 independent clears
      hw(3'd4, 16'h0002);
      chk("R8 done cleared", done, 0);
      chk("R8 err kept", err, 1);
      hw(3'd4, 16'h0004);
      chk("R8 err cleared", err, 0);

      // R5 compare latency: write then read same word
      run(mk(2'b00, 3'd2, 4'b0001, 4'b0000), cyc);
      chk("R5 write-read clean", err, 0);

      // R7 and R1: go and bound write during a run are ignored
      hw(3'd4, 16'h0002);
      hw(3'd3, mk(2'b00, 3'd2, 4'b0001, 4'b0000));
      tr_n = 0;
      hw(3'd4, 16'h0001);
      cyc = 0;
      while (!done && cyc < 2000) begin
         if (cyc == 2) begin host_wr = 1'b1; host_addr = 3'd1; host_wdata = 16'd0; end
         if (cyc == 3) begin host_wr = 1'b1; host_addr = 3'd4; host_wdata = 16'h0001; end
         if (cyc == 4) host_wr = 1'b0;
         @(negedge clk);
         cyc++;
      end
      host_wr = 1'b0;
      chk("R7 cycles unchanged", cyc, 15);
      chk("R1 first addr kept", tr_a[0], 3);
      repeat (5) @(negedge clk);
      chk("R7 no second run", busy, 0);
      chk("R7 no extra access", tr_n, 14);
      run(mk(2'b00, 3'd1, 4'b0000, 4'b0000), cyc);
      chk("R1 low bound kept", tr_a[0], 3);

      // R9 zero and clamped count
      run(mk(2'b00, 3'd0, 4'b0000, 4'b0000), cyc);
      chk("R9 zero count cycles", cyc, 1);
      chk("R9 zero count no access", tr_n, 0);
      run(mk(2'b00, 3'd7, 4'b0000, 4'b0000), cyc);
      chk("R9 clamp trace", tr_n, 28);
      chk("R9 clamp cycles", cyc, 29);
      chk("R9 clamp clean", err, 0);

      // R10 March C- clean and with stuck bits
      hw(3'd0, 16'h0000); hw(3'd1, 16'd0); hw(3'd2, 16'd15);
      march_c(tot);
      chk("R10 total cycles", tot, 10 * N + 6);
      chk("R10 clean memory", err, 0);
      for (int a = 0; a < N; a++) begin
         for (int v = 0; v < 2; v++) begin
            hw(3'd4, 16'h0004);
            flt_on = 1'b1; flt_a = AW'(a); flt_b = a % DW; flt_v = v[0];
            march_c(tot);
            k = 1 << (a % DW);
            chk("R10 stuck flagged", err, 1);
            chk("R10 stuck address", fail_addr, a);
            chk("R10 stuck data", fail_data, v ? k : (~k & 8'hFF));
         end
      end
      flt_on = 1'b0;
      finish_up();
   end
endmodule